// File: doc/BRIEF.md
# Superscalar Issue Hazard Cross-Check

This block sits at the issue stage of an in-order pipeline that handles a group of `WIDTH` decoded instructions per cycle (four by default). The group arrives in program order in numbered slots, slot 0 being the oldest. Every slot carries a valid bit, two source register numbers, a destination register number with its write-enable, and flags that mark it as a load or a store. The block answers one question each cycle: how many of the oldest slots can leave together. It returns that answer both as a count and as a thermometer mask.

A slot is held when it reads a register that an older slot of the same group writes, when it reads the destination of a load that issued in one of the last `LOAD_LAT` cycles, when it is the second memory operation of the group, or when it is an empty lane. The first held slot ends the group, and every younger slot waits with it, so issue stays in program order. Register 0 always reads as zero and is never a dependence. An internal history of the destinations of loads that actually issued feeds the load-to-use test. The rest of the path is combinational from the slot inputs.

Top module: `xchk_top`

## Requirements
- R1: Reset empties the load history, so a load offered during reset never stalls a reader in the first cycle after reset.
- R2: When all slots are valid and none has a hazard, `issue_cnt` equals `WIDTH` and every bit of `issue_mask` is set.
- R3: A valid slot whose first or second source equals the destination of any older valid slot that has its write-enable high stops issue at that slot, so `issue_cnt` equals its slot index.
- R4: A destination of register 0 never creates a dependence, even with its write-enable high.
- R5: A destination whose write-enable is low never creates a dependence.
- R6: With `LOAD_LAT` = 1, a slot that reads the destination of a load issued in the previous cycle stops issue at that slot; one cycle later, with no new load, the same group issues in full.
- R7: Loads and stores share one memory port: the second slot in the group with a load or store flag set stops issue at that slot.
- R8: An invalid slot never issues and stops issue at its index, so `issue_cnt` never exceeds the number of leading valid slots; an all-invalid group gives 0.
- R9: `issue_mask` bit i is set exactly when i is less than `issue_cnt`.
- R10: A load that is held back, or a load whose destination is register 0, leaves no entry in the load history.
- R11: Slots younger than a held slot are held too, even when they have no hazard of their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_valid | input | WIDTH | Slot holds a real instruction |
| slot_rs1 | input | WIDTH*REG_BITS | First source register of each slot, slot i in bits [i*REG_BITS +: REG_BITS] |
| slot_rs2 | input | WIDTH*REG_BITS | Second source register of each slot, same packing |
| slot_rd | input | WIDTH*REG_BITS | Destination register of each slot, same packing |
| slot_rd_we | input | WIDTH | Destination is written |
| slot_load | input | WIDTH | Slot is a load |
| slot_store | input | WIDTH | Slot is a store |
| issue_cnt | output | $clog2(WIDTH+1) | Number of leading slots that issue this cycle |
| issue_mask | output | WIDTH | Thermometer mask of issuing slots |

## Verification
The bench builds the block at its defaults: four slots, 5-bit register numbers and a one-cycle load history. With four slots, every older-to-younger slot pair in the twelve-comparator matrix can be reached, and a hazard can be placed at each stop position from 1 to 3. The one-stage history lets a load be issued in one cycle and its reader stall in the next and then go free one cycle after that. This shows both when a history entry appears and when it leaves.

// File: rtl/xchk_pkg.sv
package xchk_pkg;

  // Reason a slot cannot issue; the lowest-index slot with a cause ends the group.
  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_EMPTY    = 3'd1,
    CAUSE_RAW      = 3'd2,
    CAUSE_LOADUSE  = 3'd3,
    CAUSE_MEMPORT  = 3'd4
  } stop_cause_e;

  // Width of a count that can hold 0..w.
  function automatic int count_bits(input int w);
    return $clog2(w + 1);
  endfunction

  // A source is matched by a producer only when the producer really writes a
  // non-zero register.
  function automatic logic reg_match(input logic [15:0] src,
                                     input logic [15:0] dst,
                                     input logic        dst_live);
    return dst_live && (dst != 16'd0) && (src == dst);
  endfunction

endpackage

// File: rtl/xchk_raw_matrix.sv
module xchk_raw_matrix #(
  parameter int WIDTH    = 4,
  parameter int REG_BITS = 5
) (
  input  logic [WIDTH-1:0]          slot_valid,
  input  logic [WIDTH*REG_BITS-1:0] slot_rs1,
  input  logic [WIDTH*REG_BITS-1:0] slot_rs2,
  input  logic [WIDTH*REG_BITS-1:0] slot_rd,
  input  logic [WIDTH-1:0]          slot_rd_we,
  output logic [WIDTH-1:0]          raw_hit
);
  import xchk_pkg::*;

  // Producer liveness per slot: valid, write-enabled.
  logic [WIDTH-1:0] prod_live;
  assign prod_live = slot_valid & slot_rd_we;

  // Slot 0 has no older producer.
  assign raw_hit[0] = 1'b0;

  genvar gi, gj;
  generate
    for (gi = 1; gi < WIDTH; gi++) begin : g_reader
      logic [gi-1:0] pair_hit;
      for (gj = 0; gj < gi; gj++) begin : g_writer
        logic [15:0] src_a, src_b, dst;
        assign src_a = 16'(slot_rs1[gi*REG_BITS +: REG_BITS]);
        assign src_b = 16'(slot_rs2[gi*REG_BITS +: REG_BITS]);
        assign dst   = 16'(slot_rd [gj*REG_BITS +: REG_BITS]);
        assign pair_hit[gj] = reg_match(src_a, dst, prod_live[gj]) ||
                              reg_match(src_b, dst, prod_live[gj]);
      end
      assign raw_hit[gi] = |pair_hit;
    end
  endgenerate

endmodule

// File: rtl/xchk_load_history.sv
module xchk_load_history #(
  parameter int WIDTH    = 4,
  parameter int REG_BITS = 5,
  parameter int LOAD_LAT = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WIDTH*REG_BITS-1:0] slot_rs1,
  input  logic [WIDTH*REG_BITS-1:0] slot_rs2,
  input  logic                      cap_valid,
  input  logic [REG_BITS-1:0]       cap_rd,
  output logic [WIDTH-1:0]          lu_hit
);
  import xchk_pkg::*;

  logic [LOAD_LAT-1:0] hist_v;
  logic [REG_BITS-1:0] hist_rd [LOAD_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_v     <= '0;
      hist_rd[0] <= '0;
    end else begin
      hist_v[0]  <= cap_valid;
      hist_rd[0] <= cap_rd;
    end
  end

  genvar gk, gi;
  generate
    for (gk = 1; gk < LOAD_LAT; gk++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          hist_v[gk]  <= 1'b0;
          hist_rd[gk] <= '0;
        end else begin
          hist_v[gk]  <= hist_v[gk-1];
          hist_rd[gk] <= hist_rd[gk-1];
        end
      end
    end

    for (gi = 0; gi < WIDTH; gi++) begin : g_slot
      logic [15:0] src_a, src_b;
      assign src_a = 16'(slot_rs1[gi*REG_BITS +: REG_BITS]);
      assign src_b = 16'(slot_rs2[gi*REG_BITS +: REG_BITS]);
      always_comb begin
        lu_hit[gi] = 1'b0;
        for (int k = 0; k < LOAD_LAT; k++) begin
          if (reg_match(src_a, 16'(hist_rd[k]), hist_v[k]) ||
              reg_match(src_b, 16'(hist_rd[k]), hist_v[k]))
            lu_hit[gi] = 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/xchk_mem_port.sv
module xchk_mem_port #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] slot_valid,
  input  logic [WIDTH-1:0] slot_load,
  input  logic [WIDTH-1:0] slot_store,
  output logic [WIDTH-1:0] mem_hit
);
  logic [WIDTH-1:0] is_mem;
  assign is_mem = slot_valid & (slot_load | slot_store);

  // seen[i]: some slot older than i uses the memory port.
  logic [WIDTH:0] seen;
  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_slot
      assign seen[gi+1]  = seen[gi] | is_mem[gi];
      assign mem_hit[gi] = is_mem[gi] & seen[gi];
    end
  endgenerate

endmodule

// File: rtl/xchk_top.sv
module xchk_top #(
  parameter int WIDTH    = 4,
  parameter int REG_BITS = 5,
  parameter int LOAD_LAT = 1,
  localparam int CNT_W   = xchk_pkg::count_bits(WIDTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WIDTH-1:0]          slot_valid,
  input  logic [WIDTH*REG_BITS-1:0] slot_rs1,
  input  logic [WIDTH*REG_BITS-1:0] slot_rs2,
  input  logic [WIDTH*REG_BITS-1:0] slot_rd,
  input  logic [WIDTH-1:0]          slot_rd_we,
  input  logic [WIDTH-1:0]          slot_load,
  input  logic [WIDTH-1:0]          slot_store,
  output logic [CNT_W-1:0]          issue_cnt,
  output logic [WIDTH-1:0]          issue_mask
);
  import xchk_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [WIDTH-1:0]    raw_hit;
  logic [WIDTH-1:0]    lu_hit;
  logic [WIDTH-1:0]    mem_hit;
  logic [WIDTH-1:0]    stop_vec;
  stop_cause_e         stop_cause [WIDTH];
  logic                cap_valid;
  logic [REG_BITS-1:0] cap_rd;

  xchk_raw_matrix #(.WIDTH(WIDTH), .REG_BITS(REG_BITS)) u_raw (
    .slot_valid (slot_valid),
    .slot_rs1   (slot_rs1),
    .slot_rs2   (slot_rs2),
    .slot_rd    (slot_rd),
    .slot_rd_we (slot_rd_we),
    .raw_hit    (raw_hit)
  );

  xchk_load_history #(.WIDTH(WIDTH), .REG_BITS(REG_BITS), .LOAD_LAT(LOAD_LAT)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .slot_rs1  (slot_rs1),
    .slot_rs2  (slot_rs2),
    .cap_valid (cap_valid),
    .cap_rd    (cap_rd),
    .lu_hit    (lu_hit)
  );

  xchk_mem_port #(.WIDTH(WIDTH)) u_mem (
    .slot_valid (slot_valid),
    .slot_load  (slot_load),
    .slot_store (slot_store),
    .mem_hit    (mem_hit)
  );

  // Cause per slot, in priority order.
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_cause
      always_comb begin
        if (!slot_valid[gi])   stop_cause[gi] = CAUSE_EMPTY;
        else if (raw_hit[gi])  stop_cause[gi] = CAUSE_RAW;
        else if (lu_hit[gi])   stop_cause[gi] = CAUSE_LOADUSE;
        else if (mem_hit[gi])  stop_cause[gi] = CAUSE_MEMPORT;
        else                   stop_cause[gi] = CAUSE_NONE;
      end
      assign stop_vec[gi] = (stop_cause[gi] != CAUSE_NONE);
    end
  endgenerate

  // Count: index of the first stopping slot.
  always_comb begin
    logic found;
    found     = 1'b0;
    issue_cnt = CNT_W'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (!found && stop_vec[i]) begin
        issue_cnt = CNT_W'(i);
        found     = 1'b1;
      end
    end
  end

  // Mask: a slot issues when it and every older slot are clear.
  always_comb begin
    logic clear_so_far;
    clear_so_far = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      clear_so_far  = clear_so_far & ~stop_vec[i];
      issue_mask[i] = clear_so_far;
    end
  end

  // At most one load issues; record its live non-zero destination.
  always_comb begin
    cap_valid = 1'b0;
    cap_rd    = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (issue_mask[i] && slot_load[i] && slot_rd_we[i] &&
          (slot_rd[i*REG_BITS +: REG_BITS] != '0)) begin
        cap_valid = 1'b1;
        cap_rd    = slot_rd[i*REG_BITS +: REG_BITS];
      end
    end
  end

endmodule

// File: rtl/xchk_checker.sv
module xchk_checker #(
  parameter int WIDTH    = 4,
  parameter int REG_BITS = 5,
  parameter int CNT_W    = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic [WIDTH-1:0]          slot_valid,
  input logic [WIDTH*REG_BITS-1:0] slot_rs1,
  input logic [WIDTH*REG_BITS-1:0] slot_rs2,
  input logic [WIDTH*REG_BITS-1:0] slot_rd,
  input logic [WIDTH-1:0]          slot_rd_we,
  input logic [WIDTH-1:0]          slot_load,
  input logic [WIDTH-1:0]          slot_store,
  input logic [CNT_W-1:0]          issue_cnt,
  input logic [WIDTH-1:0]          issue_mask,
  input logic [WIDTH-1:0]          stop_vec,
  input logic                      cap_valid,
  input logic [REG_BITS-1:0]       cap_rd
);

  logic [REG_BITS-1:0] s0_rs1, s0_rs2;
  assign s0_rs1 = slot_rs1[0 +: REG_BITS];
  assign s0_rs2 = slot_rs2[0 +: REG_BITS];

  a_r2_full_issue: assert property (@(posedge clk) disable iff (rst)
    (stop_vec == '0) |-> (32'(issue_cnt) == WIDTH));

  a_r6_load_use: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cap_valid) &&
     ((s0_rs1 == $past(cap_rd)) || (s0_rs2 == $past(cap_rd))))
    |-> (issue_cnt == '0));

  a_r7_one_mem: assert property (@(posedge clk) disable iff (rst)
    $countones(issue_mask & (slot_load | slot_store)) <= 1);

  a_r8_valid_only: assert property (@(posedge clk) disable iff (rst)
    (issue_mask & ~slot_valid) == '0);

  a_r9_mask_count: assert property (@(posedge clk) disable iff (rst)
    ($countones(issue_mask) == 32'(issue_cnt)) &&
    (((issue_mask + WIDTH'(1)) & issue_mask) == '0));

  a_r10_capture_issued: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> ($countones(issue_mask & slot_load) == 1) && (cap_rd != '0));

  generate
    if (WIDTH >= 2) begin : g_pair
      logic [REG_BITS-1:0] s1_rs1, s1_rs2, s0_rd;
      assign s1_rs1 = slot_rs1[REG_BITS +: REG_BITS];
      assign s1_rs2 = slot_rs2[REG_BITS +: REG_BITS];
      assign s0_rd  = slot_rd[0 +: REG_BITS];
      a_r3_raw_slot1: assert property (@(posedge clk) disable iff (rst)
        (slot_valid[0] && slot_rd_we[0] && (s0_rd != '0) &&
         ((s1_rs1 == s0_rd) || (s1_rs2 == s0_rd)))
        |-> (32'(issue_cnt) <= 1));
    end
  endgenerate

endmodule

bind xchk_top xchk_checker #(.WIDTH(WIDTH), .REG_BITS(REG_BITS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_valid (slot_valid),
  .slot_rs1   (slot_rs1),
  .slot_rs2   (slot_rs2),
  .slot_rd    (slot_rd),
  .slot_rd_we (slot_rd_we),
  .slot_load  (slot_load),
  .slot_store (slot_store),
  .issue_cnt  (issue_cnt),
  .issue_mask (issue_mask),
  .stop_vec   (stop_vec),
  .cap_valid  (cap_valid),
  .cap_rd     (cap_rd)
);

// File: tb/sim_xchk_top.sv
module sim_xchk_top;
  localparam int W      = 4;
  localparam int RB     = 5;
  localparam int CW     = $clog2(W + 1);
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]    slot_valid, slot_rd_we, slot_load, slot_store;
  logic [W*RB-1:0] slot_rs1, slot_rs2, slot_rd;
  logic [CW-1:0]   issue_cnt;
  logic [W-1:0]    issue_mask;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  xchk_top #(.WIDTH(W), .REG_BITS(RB), .LOAD_LAT(1)) u0 (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_rs1(slot_rs1),
    .slot_rs2(slot_rs2), .slot_rd(slot_rd), .slot_rd_we(slot_rd_we),
    .slot_load(slot_load), .slot_store(slot_store),
    .issue_cnt(issue_cnt), .issue_mask(issue_mask)
  );

  task automatic clr_group();
    slot_valid = '0; slot_rd_we = '0; slot_load = '0; slot_store = '0;
    slot_rs1 = '0; slot_rs2 = '0; slot_rd = '0;
  endtask

  task automatic put(input int i, input int a, input int b, input int d,
                     input bit we, input bit ld, input bit st);
    slot_valid[i] = 1'b1;
    slot_rs1[i*RB +: RB] = RB'(a);
    slot_rs2[i*RB +: RB] = RB'(b);
    slot_rd[i*RB +: RB]  = RB'(d);
    slot_rd_we[i] = we; slot_load[i] = ld; slot_store[i] = st;
  endtask

  // Sources r1..r8, destinations r16..r19: no overlap.
  task automatic fill_indep();
    clr_group();
    for (int i = 0; i < W; i++) put(i, 1 + i, 5 + i, 16 + i, 1'b1, 1'b0, 1'b0);
  endtask

  // Group is driven after a falling edge; outputs sampled 1 unit later.
  task automatic check(input int exp, input string req);
    logic [W-1:0] exp_mask;
    #1;
    exp_mask = '0;
    for (int i = 0; i < W; i++) exp_mask[i] = (i < exp);
    n_checks++;
    if (int'(issue_cnt) != exp || issue_mask != exp_mask) begin
      n_fails++;
      $display("FAIL %s: cnt=%0d mask=%b expected cnt=%0d mask=%b",
               req, issue_cnt, issue_mask, exp, exp_mask);
    end
  endtask

  task automatic flush();
    @(negedge clk); clr_group(); check(0, "R8 empty group");
  endtask

  task automatic t_reset();
    clr_group();
    put(0, 1, 2, 7, 1'b1, 1'b1, 1'b0);      // load r7 offered during reset
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    fill_indep(); slot_rs1[0 +: RB] = RB'(7);
    check(4, "R1 history empty after reset");
    flush();
  endtask

  task automatic t_indep();
    @(negedge clk); fill_indep(); check(4, "R2 independent group");
    @(negedge clk); fill_indep();
    for (int i = 0; i < W; i++) put(i, 12 + i, 3, 24 + i, 1'b1, 1'b0, 1'b0);
    check(4, "R2 second independent pattern");
  endtask

  task automatic t_raw();
    @(negedge clk); fill_indep(); slot_rs1[1*RB +: RB] = RB'(16);
    check(1, "R3 slot1 rs1 from slot0");
    @(negedge clk); fill_indep(); slot_rs2[2*RB +: RB] = RB'(16);
    check(2, "R3 slot2 rs2 from slot0");
    @(negedge clk); fill_indep(); slot_rs1[3*RB +: RB] = RB'(18);
    check(3, "R3 slot3 rs1 from slot2");
    @(negedge clk); fill_indep(); slot_rs2[3*RB +: RB] = RB'(17);
    check(3, "R3 slot3 rs2 from slot1");
  endtask

  task automatic t_prefix();
    @(negedge clk); fill_indep(); slot_rs2[1*RB +: RB] = RB'(16);
    check(1, "R11 younger clean slots held");
  endtask

  task automatic t_r0();
    @(negedge clk); fill_indep();
    put(0, 1, 2, 0, 1'b1, 1'b0, 1'b0);
    slot_rs1[1*RB +: RB] = RB'(0); slot_rs2[3*RB +: RB] = RB'(0);
    check(4, "R4 register 0 no dependence");
  endtask

  task automatic t_we();
    @(negedge clk); fill_indep();
    put(0, 1, 2, 5, 1'b0, 1'b0, 1'b0);
    slot_rs1[1*RB +: RB] = RB'(5); slot_rs2[2*RB +: RB] = RB'(5);
    check(4, "R5 write-enable low ignored");
  endtask

  task automatic t_mem();
    @(negedge clk); fill_indep();
    put(0, 1, 2, 20, 1'b1, 1'b1, 1'b0);
    put(2, 3, 4, 0, 1'b0, 1'b0, 1'b1);
    check(2, "R7 store after load");
    flush();
    @(negedge clk); fill_indep();
    put(1, 3, 4, 0, 1'b0, 1'b0, 1'b1);
    put(3, 5, 6, 21, 1'b1, 1'b1, 1'b0);
    check(3, "R7 load after store");
    flush();
  endtask

  task automatic t_loaduse();
    @(negedge clk); clr_group(); put(0, 1, 2, 9, 1'b1, 1'b1, 1'b0);
    check(1, "R6 load issues");
    @(negedge clk); fill_indep(); slot_rs2[1*RB +: RB] = RB'(9);
    check(1, "R6 reader in next cycle stalls");
    @(negedge clk); fill_indep(); slot_rs2[1*RB +: RB] = RB'(9);
    check(4, "R6 stall clears after one cycle");
    @(negedge clk); clr_group(); put(0, 1, 2, 9, 1'b1, 1'b1, 1'b0);
    check(1, "R6 load issues again");
    @(negedge clk); fill_indep(); slot_rs1[0 +: RB] = RB'(9);
    check(0, "R6 slot0 reader stalls");
    flush();
  endtask

  task automatic t_unissued();
    @(negedge clk); fill_indep();
    put(0, 1, 2, 11, 1'b1, 1'b0, 1'b0);
    slot_rs1[1*RB +: RB] = RB'(11);
    put(2, 3, 4, 14, 1'b1, 1'b1, 1'b0);
    check(1, "R10 held load setup");
    @(negedge clk); fill_indep(); slot_rs1[0 +: RB] = RB'(14);
    check(4, "R10 held load leaves no entry");
    @(negedge clk); clr_group(); put(0, 1, 2, 0, 1'b1, 1'b1, 1'b0);
    check(1, "R10 load to r0 issues");
    @(negedge clk); fill_indep(); slot_rs1[0 +: RB] = RB'(0);
    check(4, "R10 load to r0 leaves no entry");
  endtask

  task automatic t_invalid();
    @(negedge clk); fill_indep(); slot_valid[2] = 1'b0;
    check(2, "R8 hole at slot2");
    @(negedge clk); fill_indep(); slot_valid[0] = 1'b0;
    check(0, "R8 hole at slot0");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    clr_group();
    t_reset();
    t_indep();
    t_raw();
    t_prefix();
    t_r0();
    t_we();
    t_mem();
    t_loaduse();
    t_unissued();
    t_invalid();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

endmodule